// File: doc/BRIEF.md
# Message-Signalled Interrupt Capability Registers

This block holds the configuration-space registers of a message-signalled interrupt capability. Configuration software uses them to set the message address, the data value and the number of enabled vectors, and to mask single vectors. Parameters fix the vector count (1, 2, 4, 8, 16 or 32), whether a 64-bit message address is offered, and whether per-vector masking is offered. These options set both the register layout and the length of the capability window. The block decodes dword-addressed configuration writes and reads that fall inside the window and applies a fixed write mask to each field. It honours byte enables for each lane.

The message generator beside it reads the live enable, address, data, mask and enabled vector count from output pins. It records and retires pending vectors through the set and clear pins. When a configuration write leaves the function enabled, the block does three things. It sends a one-cycle pulse that tells the legacy wire interrupt logic to drop its request. It clamps an illegal enabled-vector count. It discards pending bits at or above the enabled count.

All pins are plain control and status signals. No stream interface crosses the block edge, so there is no back-pressure. A write is taken on every clock edge where `cfg_wr` is high, and `cfg_rdata` follows `cfg_dwaddr` combinationally.

Top module: `msicap_regs`

## Requirements
- R1: The window starts at dword CAP_BASE/4. It spans 3 dwords with neither option, 4 with 64-bit addressing only, 5 with masking only, and 6 with both (capability lengths 0x0A, 0x0E, 0x14 and 0x18 bytes). Reads of dwords outside it return zero.
- R2: The control word sits in bits 31:16 of the first dword. Its bit 0 is enable, bits 3:1 hold log2 of the vector count (read-only), bits 6:4 hold the enabled count as log2, bit 7 is 64-bit capable and bit 8 is mask capable. Only enable and bits 6:4 are writable. Bits 15:0 of that dword read as zero.
- R3: The low address sits in dword +1, and its bits 1:0 always read as zero. With 64-bit addressing, dword +2 is a fully writable upper address.
- R4: Message data sits in bits 15:0 of dword +2 (32-bit) or dword +3 (64-bit) and is fully writable. Bits 31:16 of that dword read as zero.
- R5: With masking, the mask register follows the data dword. Only bits 0 to N-1 are writable, and the higher bits read as zero.
- R6: With masking, the pending register follows the mask. Configuration writes do not change it. A high `pend_set` bit sets the matching pending bit at the next edge, and a high `pend_clr` bit clears it; clear wins over set.
- R7: Each byte lane of a write is applied only when its `cfg_be` bit is set.
- R8: Reset clears enable, the enabled count, both address words, the data, the mask and the pending bits.
- R9: If a write leaves enable set and the enabled count is greater than the capable count, the capable count is stored instead.
- R10: Any in-window write that leaves enable set raises `intx_deassert` for exactly the one cycle after the write edge. Other writes do not raise it.
- R11: That same write clears every pending bit at or above 2^(enabled count). The clearing is applied after that cycle's set and clear.
- R12: Writes outside the window change no register.
- R13: `msi_en`, `msi_vec_log2`, `msi_addr` ({upper, low}), `msi_data`, `msi_mask` and `msi_pend` show the current register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_dwaddr | input | 6 | Configuration dword address |
| cfg_wr | input | 1 | Write strobe, one write per edge |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_dwaddr (combinational) |
| pend_set | input | NUM_VEC | Pending-set request per vector |
| pend_clr | input | NUM_VEC | Pending-clear request per vector |
| msi_en | output | 1 | Enable bit |
| msi_vec_log2 | output | 3 | Enabled vector count, log2 |
| msi_addr | output | 64 | Message address |
| msi_data | output | 16 | Message data |
| msi_mask | output | NUM_VEC | Per-vector mask |
| msi_pend | output | NUM_VEC | Per-vector pending |
| intx_deassert | output | 1 | One-cycle pulse that drops legacy wire request |

## Verification
Every register update is one edge deep. A write or a set/clear presented before an edge shows up in `cfg_rdata` and on the export pins right after that edge. `intx_deassert` is high for the cycle that follows the write edge and low again one edge later. The bench drives inputs on the falling edge and samples read data and pulse state at the next falling edge, or shortly after changing the read address. Each check therefore lands inside the single cycle where its result is due, and the pulse is checked both in that cycle and in the cycle after it.

// File: rtl/msicap_pkg.sv
`timescale 1ns/1ps
package msicap_pkg;
  // one-hot register select inside the window
  typedef struct packed {
    logic ctl;
    logic alo;
    logic ahi;
    logic dat;
    logic msk;
    logic pnd;
  } regsel_t;

  // window length in dwords for an option set
  function automatic int unsigned cap_dwords(bit a64, bit pvm);
    return 3 + (a64 ? 1 : 0) + (pvm ? 2 : 0);
  endfunction
endpackage

// File: rtl/msicap_decode.sv
`timescale 1ns/1ps
module msicap_decode
  import msicap_pkg::*;
#(
  parameter int unsigned CAP_BASE = 'h50,
  parameter bit          ADDR64   = 1'b1,
  parameter bit          PV_MASK  = 1'b1
) (
  input  logic [5:0] dwaddr,
  output logic       hit,
  output regsel_t    sel
);
  localparam logic [6:0] BASE_DW = 7'(CAP_BASE >> 2);
  localparam logic [6:0] NDW     = 7'(cap_dwords(ADDR64, PV_MASK));
  localparam logic [6:0] DAT_DW  = ADDR64 ? 7'd3 : 7'd2;

  logic [6:0] rel;

  always_comb begin
    rel     = {1'b0, dwaddr} - BASE_DW;
    hit     = (rel < NDW);
    sel.ctl = hit && (rel == 7'd0);
    sel.alo = hit && (rel == 7'd1);
    sel.ahi = hit && ADDR64 && (rel == 7'd2);
    sel.dat = hit && (rel == DAT_DW);
    sel.msk = hit && PV_MASK && (rel == DAT_DW + 7'd1);
    sel.pnd = hit && PV_MASK && (rel == DAT_DW + 7'd2);
  end
endmodule

// File: rtl/msicap_ctrl.sv
`timescale 1ns/1ps
module msicap_ctrl #(
  parameter logic [2:0] MMC = 3'd3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_hit,
  input  logic       wr_ctl,
  input  logic       wr_en_bit,
  input  logic [2:0] wr_mme,
  output logic       en_q,
  output logic [2:0] mme_q,
  output logic [2:0] mme_next,
  output logic       drop_req,
  output logic       intx_pulse
);
  logic       en_next;
  logic [2:0] mme_raw;

  always_comb begin
    en_next  = wr_ctl ? wr_en_bit : en_q;
    mme_raw  = wr_ctl ? wr_mme : mme_q;
    drop_req = wr_hit && en_next;
    mme_next = (drop_req && (mme_raw > MMC)) ? MMC : mme_raw;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      mme_q      <= 3'd0;
      intx_pulse <= 1'b0;
    end else begin
      en_q       <= en_next;
      mme_q      <= mme_next;
      intx_pulse <= drop_req;
    end
  end

  // R9
  clamp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |-> (mme_q <= MMC));

  // R10
  intx_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    intx_pulse |-> en_q);

  // R10
  intx_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> !intx_pulse);
endmodule

// File: rtl/msicap_vecbits.sv
`timescale 1ns/1ps
module msicap_vecbits #(
  parameter int unsigned NUM_VEC = 8,
  parameter bit          PV_MASK = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_msk,
  input  logic [3:0]         be,
  input  logic [NUM_VEC-1:0] wbits,
  input  logic [NUM_VEC-1:0] pend_set,
  input  logic [NUM_VEC-1:0] pend_clr,
  input  logic               drop_req,
  input  logic [2:0]         mme_next,
  output logic [NUM_VEC-1:0] mask_q,
  output logic [NUM_VEC-1:0] pend_q
);
  logic [NUM_VEC-1:0] keep;

  always_comb begin
    for (int i = 0; i < NUM_VEC; i++)
      keep[i] = ((32'(i) >> mme_next) == 32'd0);
  end

  if (PV_MASK) begin : g_mask
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mask_q <= '0;
        pend_q <= '0;
      end else begin
        for (int i = 0; i < NUM_VEC; i++)
          if (wr_msk && be[i/8]) mask_q[i] <= wbits[i];
        pend_q <= ((pend_q | pend_set) & ~pend_clr) & (drop_req ? keep : '1);
      end
    end

    // R6
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_set[0] && !pend_clr[0]) |=> pend_q[0]);

    // R6
    pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_clr[0] |=> !pend_q[0]);
  end else begin : g_nomask
    assign mask_q = '0;
    assign pend_q = '0;
  end
endmodule

// File: rtl/msicap_regs.sv
`timescale 1ns/1ps
module msicap_regs
  import msicap_pkg::*;
#(
  parameter int unsigned NUM_VEC  = 8,
  parameter bit          ADDR64   = 1'b1,
  parameter bit          PV_MASK  = 1'b1,
  parameter int unsigned CAP_BASE = 'h50
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [5:0]         cfg_dwaddr,
  input  logic               cfg_wr,
  input  logic [3:0]         cfg_be,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  input  logic [NUM_VEC-1:0] pend_set,
  input  logic [NUM_VEC-1:0] pend_clr,
  output logic               msi_en,
  output logic [2:0]         msi_vec_log2,
  output logic [63:0]        msi_addr,
  output logic [15:0]        msi_data,
  output logic [NUM_VEC-1:0] msi_mask,
  output logic [NUM_VEC-1:0] msi_pend,
  output logic               intx_deassert
);
  localparam logic [2:0] MMC = 3'($clog2(NUM_VEC));

  logic        hit, wr_hit, drop_req;
  regsel_t     sel;
  logic [2:0]  mme_next;
  logic [31:0] alo_q, ahi_q;
  logic [15:0] data_q;
  logic [15:0] ctl16;

  msicap_decode #(.CAP_BASE(CAP_BASE), .ADDR64(ADDR64), .PV_MASK(PV_MASK)) u_dec (
    .dwaddr(cfg_dwaddr), .hit(hit), .sel(sel));

  assign wr_hit = cfg_wr && hit;

  msicap_ctrl #(.MMC(MMC)) u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit),
    .wr_ctl(wr_hit && sel.ctl && cfg_be[2]),
    .wr_en_bit(cfg_wdata[16]), .wr_mme(cfg_wdata[22:20]),
    .en_q(msi_en), .mme_q(msi_vec_log2), .mme_next(mme_next),
    .drop_req(drop_req), .intx_pulse(intx_deassert));

  msicap_vecbits #(.NUM_VEC(NUM_VEC), .PV_MASK(PV_MASK)) u_vec (
    .clk(clk), .rst_n(rst_n), .wr_msk(wr_hit && sel.msk), .be(cfg_be),
    .wbits(cfg_wdata[NUM_VEC-1:0]), .pend_set(pend_set), .pend_clr(pend_clr),
    .drop_req(drop_req), .mme_next(mme_next),
    .mask_q(msi_mask), .pend_q(msi_pend));

  // address and data words, merged per byte lane
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alo_q  <= '0;
      data_q <= '0;
    end else begin
      for (int b = 0; b < 4; b++)
        if (wr_hit && sel.alo && cfg_be[b])
          alo_q[8*b +: 8] <= cfg_wdata[8*b +: 8] & ((b == 0) ? 8'hFC : 8'hFF);
      for (int b = 0; b < 2; b++)
        if (wr_hit && sel.dat && cfg_be[b])
          data_q[8*b +: 8] <= cfg_wdata[8*b +: 8];
    end
  end

  if (ADDR64) begin : g_hi
    always_ff @(posedge clk) begin
      if (!rst_n) ahi_q <= '0;
      else
        for (int b = 0; b < 4; b++)
          if (wr_hit && sel.ahi && cfg_be[b]) ahi_q[8*b +: 8] <= cfg_wdata[8*b +: 8];
    end
  end else begin : g_lo_only
    assign ahi_q = '0;
  end

  assign msi_addr = {ahi_q, alo_q};
  assign msi_data = data_q;

  always_comb begin
    ctl16 = {7'd0, PV_MASK, ADDR64, msi_vec_log2, MMC, msi_en};
    if (sel.ctl)      cfg_rdata = {ctl16, 16'h0000};
    else if (sel.alo) cfg_rdata = alo_q;
    else if (sel.ahi) cfg_rdata = ahi_q;
    else if (sel.dat) cfg_rdata = {16'h0000, data_q};
    else if (sel.msk) cfg_rdata = 32'(msi_mask);
    else if (sel.pnd) cfg_rdata = 32'(msi_pend);
    else              cfg_rdata = '0;
  end

  // pending bits that the current enabled count keeps
  logic [NUM_VEC-1:0] keep_now;
  always_comb begin
    for (int i = 0; i < NUM_VEC; i++)
      keep_now[i] = ((32'(i) >> msi_vec_log2) == 32'd0);
  end

  // R11
  drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    intx_deassert |-> ((msi_pend & ~keep_now) == '0));

  // R12
  outside_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !hit) |=> ($stable(alo_q) && $stable(data_q) && $stable(msi_en)
                          && $stable(msi_mask)));

  // R3
  alo_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel.alo |-> (cfg_rdata[1:0] == 2'b00));
endmodule

// File: tb/test_msicap_regs.sv
`timescale 1ns/1ps
module test_msicap_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  cfg_dwaddr = '0;
  logic        cfg_wr = 1'b0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] rdata_a, rdata_b;
  logic [7:0]  pset = '0, pclr = '0;
  logic        en_a, intx_a, en_b, intx_b;
  logic [2:0]  vl_a, vl_b;
  logic [63:0] addr_a, addr_b;
  logic [15:0] data_a, data_b;
  logic [7:0]  mask_a, pend_a;
  logic [0:0]  mask_b, pend_b;
  int total = 0, bad = 0;
  logic intx_seen_a, intx_seen_b;

  always #2.5 clk = ~clk;

  msicap_regs #(.NUM_VEC(8), .ADDR64(1'b1), .PV_MASK(1'b1), .CAP_BASE('h50)) i_msicap_regs (
    .clk(clk), .rst_n(rst_n), .cfg_dwaddr(cfg_dwaddr), .cfg_wr(cfg_wr), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(rdata_a), .pend_set(pset), .pend_clr(pclr),
    .msi_en(en_a), .msi_vec_log2(vl_a), .msi_addr(addr_a), .msi_data(data_a),
    .msi_mask(mask_a), .msi_pend(pend_a), .intx_deassert(intx_a));

  msicap_regs #(.NUM_VEC(1), .ADDR64(1'b0), .PV_MASK(1'b0), .CAP_BASE('h40)) i_msicap_regs_lean (
    .clk(clk), .rst_n(rst_n), .cfg_dwaddr(cfg_dwaddr), .cfg_wr(cfg_wr), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(rdata_b), .pend_set(1'b0), .pend_clr(1'b0),
    .msi_en(en_b), .msi_vec_log2(vl_b), .msi_addr(addr_b), .msi_data(data_b),
    .msi_mask(mask_b), .msi_pend(pend_b), .intx_deassert(intx_b));

  // {byte address, byte enables, write data, expected read-back}
  localparam logic [75:0] TBL [0:11] = '{
    {8'h54, 4'hF, 32'h12345677, 32'h12345674},  // R3 low bits zero
    {8'h54, 4'h1, 32'h000000FF, 32'h123456FC},  // R7 lane 0 only
    {8'h58, 4'hF, 32'hDEADBEEF, 32'hDEADBEEF},  // R3 upper address
    {8'h5C, 4'hF, 32'hFFFFA5A5, 32'h0000A5A5},  // R4 data width
    {8'h60, 4'hF, 32'hFFFFFFFF, 32'h000000FF},  // R5 mask bits < N
    {8'h64, 4'hF, 32'hFFFFFFFF, 32'h00000000},  // R6 pending read-only
    {8'h50, 4'hF, 32'h00700000, 32'h01F60000},  // R2 no clamp while disabled
    {8'h50, 4'hF, 32'h00710000, 32'h01B70000},  // R9 clamp to capable
    {8'h50, 4'h3, 32'h00000000, 32'h01B70000},  // R7 control lane off
    {8'h50, 4'hF, 32'hFFFF0000, 32'h01B70000},  // R2 read-only bits
    {8'h68, 4'hF, 32'hFFFFFFFF, 32'h00000000},  // R1 outside window
    {8'h50, 4'hF, 32'h00000000, 32'h01860000}   // R2 disable
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_dwaddr = a[7:2]; cfg_be = be; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    intx_seen_a = intx_a;
    intx_seen_b = intx_b;
  endtask

  task automatic rd(input logic [7:0] a);
    cfg_dwaddr = a[7:2];
    #1;
  endtask

  initial begin : watchdog
    #(5ns * 20000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 R2 reset state
    rd(8'h50); check("R2 reset ctrl", rdata_a, 32'h01860000);
    rd(8'h54); check("R8 reset addr lo", rdata_a, 0);
    rd(8'h64); check("R8 reset pending", rdata_a, 0);
    check("R10 idle pulse", intx_a, 0);
    rd(8'h40); check("R2 lean ctrl", rdata_b, 32'h00000000);

    for (int k = 0; k < 12; k++) begin
      wr(TBL[k][75:68], TBL[k][67:64], TBL[k][63:32]);
      rd(TBL[k][75:68]);
      check($sformatf("R1-table entry %0d", k), rdata_a, TBL[k][31:0]);
    end

    // R13 exports
    check("R13 addr", addr_a, 64'hDEADBEEF_123456FC);
    check("R13 data", data_a, 16'hA5A5);
    check("R13 mask", mask_a, 8'hFF);
    check("R13 en", en_a, 0);

    // R6 set / clear ports
    @(negedge clk); pset = 8'hFF;
    @(negedge clk); pset = 8'h00; pclr = 8'h01;
    rd(8'h64); check("R6 set", rdata_a, 32'hFF);
    @(negedge clk); pclr = 8'h00;
    rd(8'h64); check("R6 clear", rdata_a, 32'hFE);
    check("R13 pend", pend_a, 8'hFE);

    // R10 R11 enable with two vectors
    wr(8'h50, 4'hF, 32'h00110000);
    check("R10 pulse", intx_seen_a, 1);
    rd(8'h64); check("R11 drop", rdata_a, 32'h02);
    rd(8'h50); check("R2 ctrl en", rdata_a, 32'h01970000);
    check("R13 vec log2", vl_a, 3'd1);
    check("R13 en set", en_a, 1);
    @(negedge clk); check("R10 one cycle", intx_a, 0);
    wr(8'h50, 4'hF, 32'h00000000);
    check("R10 none when disabled", intx_seen_a, 0);

    // R12 outside writes
    wr(8'h4C, 4'hF, 32'hFFFFFFFF);
    rd(8'h54); check("R12 addr kept", rdata_a, 32'h123456FC);
    rd(8'h4C); check("R1 lean window end", rdata_b, 0);
    check("R12 lean data", data_b, 16'h0000);

    // lean instance: clamp to 0, data at +8
    wr(8'h40, 4'hF, 32'h00710000);
    check("R10 lean pulse", intx_seen_b, 1);
    rd(8'h40); check("R9 lean clamp", rdata_b, 32'h00010000);
    wr(8'h48, 4'hF, 32'h1234ABCD);
    rd(8'h48); check("R4 lean data", rdata_b, 32'h0000ABCD);
    check("R3 lean upper zero", addr_b[63:32], 0);

    // R8 reset after programming
    @(negedge clk); pset = 8'h0F;
    @(negedge clk); pset = 8'h00; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    rd(8'h50); check("R8 ctrl", rdata_a, 32'h01860000);
    rd(8'h58); check("R8 addr hi", rdata_a, 0);
    rd(8'h5C); check("R8 data", rdata_a, 0);
    rd(8'h60); check("R8 mask", rdata_a, 0);
    rd(8'h64); check("R8 pending", rdata_a, 0);
    rd(8'h40); check("R8 lean ctrl", rdata_b, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule